// File: doc/BRIEF.md
# Adaptive Balancing-Time Controller

This block tunes the length of the charge-sharing pulse that a complementary two-phase clock generator fires before each clock edge. At the moment the clock drivers are switched back on, a one-bit equilibrium indication is latched. A latched 0 means the two phases had not met in time, so the pulse was too short. A latched 1 means the pulse was long enough. The controller uses this bit to probe for the shortest pulse that still reaches equilibrium.

The chosen setting is held as a one-hot position that saturates at both ends. There are four positions, which give non-uniform pulse lengths of 1, 2, 4 and 7 delay units. A free-running pace counter permits at most one move per window of 16 clock cycles, so the pulse length settles over several windows. The phase sequencer reads the binary select code and the matching unit count. A limit flag reports when the setting sits at either end of the range.

Top module: `balance_time_ctrl`

## Requirements
- R1: When `drv_en_i` is 1 at a rising clock edge, the internal capture bit takes the value of `eq_det_i`. When `drv_en_i` is 0, the capture bit holds and `eq_det_i` has no effect.
- R2: A 4-bit pace counter counts every clock and wraps. `sel_o` may change only at the edge where the counter reads 15. The first such edge is the 16th rising edge after reset is released, and the next ones follow every 16 edges.
- R3: At an adjustment edge, a capture bit of 0 moves `sel_o` one step up, which is longer. At 3 it stays at 3. After a shorter step whose capture is 0, this returns the setting to the longer value.
- R4: At an adjustment edge, a capture bit of 1 moves `sel_o` one step down, which is shorter. At 0 it stays at 0.
- R5: `sel_o` values 0, 1, 2 and 3 select pulses of 1, 2, 4 and 7 delay units. `dly_units_o` carries that unit count.
- R6: While `rst_ni` is 0 (asynchronous, active low), `sel_o` is 3, the pace counter is 0 and the capture bit is 0.
- R7: `at_limit_o` is 1 exactly when `sel_o` is 0 or 3.
- R8: An adjustment uses the capture bit held before the adjusting edge. A strobe in that same cycle only affects the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eq_det_i | input | 1 | Equilibrium reached indication |
| drv_en_i | input | 1 | Driver re-enable strobe, sampled each edge |
| sel_o | output | 2 | Pulse length select, 0 shortest to 3 longest |
| dly_units_o | output | 3 | Pulse length in delay units (1, 2, 4 or 7) |
| at_limit_o | output | 1 | Setting is at the shortest or longest end |

## Verification
The properties assume that `eq_det_i` and `drv_en_i` are clean synchronous levels that are stable around each rising edge. They also assume that `rst_ni` is held low long enough to cover at least one edge before the first checked cycle. The bench changes every input 2 ns after a rising edge and never near the following one. It asserts reset from time zero. Both the directed windows and the random stretch keep to this rule, so any strobe pattern, including a strobe on the adjusting edge itself, is legal stimulus.

// File: rtl/balance_time_pkg.sv
package balance_time_pkg;

    typedef enum logic [1:0] {
        MOVE_HOLD    = 2'd0,
        MOVE_LONGER  = 2'd1,
        MOVE_SHORTER = 2'd2
    } move_e;

    // Pulse length for a setting index: powers of two, except the top
    // index, which uses the all-ones value of its width.
    function automatic int unsigned step_units(input int unsigned idx,
                                               input int unsigned n);
        if (idx == n - 1) begin
            return (32'd1 << idx) - 32'd1;
        end
        return 32'd1 << idx;
    endfunction

endpackage

// File: rtl/balance_time_pace.sv
module balance_time_pace #(
    parameter int unsigned PACE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [PACE_W-1:0] cnt_o,
    output logic              due_o
);
    localparam logic [PACE_W-1:0] LAST = '1;

    typedef struct packed {
        logic [PACE_W-1:0] cnt;
    } pace_t;

    pace_t pace_d, pace_q;

    always_comb begin
        pace_d     = pace_q;
        pace_d.cnt = pace_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pace_q <= '0;
        end else begin
            pace_q <= pace_d;
        end
    end

    assign cnt_o = pace_q.cnt;
    assign due_o = (pace_q.cnt == LAST);
endmodule

// File: rtl/balance_time_capture.sv
module balance_time_capture (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic eq_i,
    output logic cap_o
);
    typedef struct packed {
        logic cap;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (strobe_i) begin
            cap_d.cap = eq_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_o = cap_q.cap;
endmodule

// File: rtl/balance_time_position.sv
module balance_time_position
    import balance_time_pkg::*;
#(
    parameter int unsigned POS_N  = 4,
    localparam int unsigned SEL_W  = $clog2(POS_N),
    localparam int unsigned UNIT_W = POS_N - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              due_i,
    input  logic              cap_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [UNIT_W-1:0] units_o,
    output logic              at_limit_o
);
    // Bit 0 is the longest setting; moving toward bit 0 lengthens the pulse.
    localparam logic [POS_N-1:0] LONGEST = POS_N'(1);

    typedef struct packed {
        logic [POS_N-1:0] pos;
    } pos_t;

    pos_t  pos_d, pos_q;
    move_e move;

    logic [SEL_W-1:0]  sel_term  [POS_N];
    logic [UNIT_W-1:0] unit_term [POS_N];

    always_comb begin
        move = MOVE_HOLD;
        if (due_i) begin
            move = cap_i ? MOVE_SHORTER : MOVE_LONGER;
        end
    end

    always_comb begin
        pos_d = pos_q;
        case (move)
            MOVE_LONGER: begin
                if (!pos_q.pos[0]) begin
                    pos_d.pos = pos_q.pos >> 1;
                end
            end
            MOVE_SHORTER: begin
                if (!pos_q.pos[POS_N-1]) begin
                    pos_d.pos = pos_q.pos << 1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q.pos <= LONGEST;
        end else begin
            pos_q <= pos_d;
        end
    end

    // Setting index k lives in bit POS_N-1-k.
    for (genvar k = 0; k < POS_N; k++) begin : g_enc
        assign sel_term[k]  = pos_q.pos[POS_N-1-k] ? SEL_W'(k) : '0;
        assign unit_term[k] = pos_q.pos[POS_N-1-k] ?
                              UNIT_W'(step_units(k, POS_N)) : '0;
    end

    always_comb begin
        sel_o   = '0;
        units_o = '0;
        for (int k = 0; k < POS_N; k++) begin
            sel_o   = sel_o | sel_term[k];
            units_o = units_o | unit_term[k];
        end
    end

    assign at_limit_o = pos_q.pos[0] | pos_q.pos[POS_N-1];
endmodule

// File: rtl/balance_time_ctrl.sv
module balance_time_ctrl #(
    parameter int unsigned POS_N  = 4,
    parameter int unsigned PACE_W = 4,
    localparam int unsigned SEL_W  = $clog2(POS_N),
    localparam int unsigned UNIT_W = POS_N - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              eq_det_i,
    input  logic              drv_en_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [UNIT_W-1:0] dly_units_o,
    output logic              at_limit_o
);
    logic [PACE_W-1:0] pace_cnt;
    logic              pace_due;
    logic              cap_q;

    balance_time_pace #(.PACE_W(PACE_W)) u_pace (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (pace_cnt),
        .due_o  (pace_due)
    );

    balance_time_capture u_capture (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (drv_en_i),
        .eq_i     (eq_det_i),
        .cap_o    (cap_q)
    );

    balance_time_position #(.POS_N(POS_N)) u_position (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .due_i      (pace_due),
        .cap_i      (cap_q),
        .sel_o      (sel_o),
        .units_o    (dly_units_o),
        .at_limit_o (at_limit_o)
    );
endmodule

// File: rtl/balance_time_ctrl_chk.sv
module balance_time_ctrl_chk #(
    parameter int unsigned POS_N  = 4,
    parameter int unsigned PACE_W = 4,
    localparam int unsigned SEL_W  = $clog2(POS_N),
    localparam int unsigned UNIT_W = POS_N - 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              eq_det_i,
    input logic              drv_en_i,
    input logic              cap_i,
    input logic              due_i,
    input logic [PACE_W-1:0] cnt_i,
    input logic [SEL_W-1:0]  sel_i,
    input logic [UNIT_W-1:0] units_i,
    input logic              at_limit_i
);
    localparam logic [SEL_W-1:0]  SEL_TOP  = SEL_W'(POS_N - 1);
    localparam logic [PACE_W-1:0] CNT_LAST = '1;

    assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drv_en_i |=> cap_i == $past(eq_det_i));

    assert_capture_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_en_i |=> $stable(cap_i));

    assert_pace_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i != CNT_LAST |=> cnt_i == PACE_W'($past(cnt_i) + 1'b1));

    assert_pace_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i == CNT_LAST |=> cnt_i == '0);

    assert_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !due_i |=> $stable(sel_i));

    assert_longer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (due_i && !cap_i && sel_i != SEL_TOP) |=> sel_i == SEL_W'($past(sel_i) + 1'b1));

    assert_longer_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (due_i && !cap_i && sel_i == SEL_TOP) |=> sel_i == SEL_TOP);

    assert_shorter_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (due_i && cap_i && sel_i != '0) |=> sel_i == SEL_W'($past(sel_i) - 1'b1));

    assert_shorter_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (due_i && cap_i && sel_i == '0) |=> sel_i == '0);

    assert_units_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        units_i == UNIT_W'(balance_time_pkg::step_units(32'(sel_i), POS_N)));

    assert_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_limit_i == (sel_i == '0 || sel_i == SEL_TOP));
endmodule

bind balance_time_ctrl balance_time_ctrl_chk #(.POS_N(POS_N), .PACE_W(PACE_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eq_det_i   (eq_det_i),
    .drv_en_i   (drv_en_i),
    .cap_i      (cap_q),
    .due_i      (pace_due),
    .cnt_i      (pace_cnt),
    .sel_i      (sel_o),
    .units_i    (dly_units_o),
    .at_limit_i (at_limit_o)
);

// File: tb/balance_time_ctrl_bench.sv
`timescale 1ns/1ps
module balance_time_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eq = 1'b0;
    logic       drv = 1'b0;
    logic [1:0] sel;
    logic [2:0] units;
    logic       lim;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    int m_cnt = 0;
    int m_cap = 0;
    int m_idx = 3;

    balance_time_ctrl u_balance_time_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .eq_det_i    (eq),
        .drv_en_i    (drv),
        .sel_o       (sel),
        .dly_units_o (units),
        .at_limit_o  (lim)
    );

    always #4 clk = ~clk;

    function automatic int exp_units(input int idx);
        return (idx == 3) ? 7 : (1 << idx);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: counter, captured bit, setting index.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_cap = 0;
            m_idx = 3;
        end else begin
            if (m_cnt == 15) begin
                if (m_cap == 0) begin
                    if (m_idx < 3) m_idx = m_idx + 1;
                end else begin
                    if (m_idx > 0) m_idx = m_idx - 1;
                end
            end
            if (drv) m_cap = int'(eq);
            m_cnt = (m_cnt + 1) % 16;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 R3 R4 R8 sel vs model", int'(sel), m_idx);
            chk("R5 units vs model", int'(units), exp_units(m_idx));
            chk("R7 limit vs model", int'(lim), (m_idx == 0 || m_idx == 3) ? 1 : 0);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        edges(3);
        chk("R6 reset sel", int'(sel), 3);
        chk("R6 reset units", int'(units), 7);
        chk("R6 reset limit", int'(lim), 1);
        cmp_on = 1'b1;

        rst_n = 1'b1; eq = 1'b1; drv = 1'b1;
        edges(15);
        chk("R2 no move before 16th edge", int'(sel), 3);
        edges(1);
        chk("R4 first shorter step", int'(sel), 2);
        chk("R5 units at 2", int'(units), 4);
        chk("R7 limit clear at 2", int'(lim), 0);
        edges(16);
        chk("R4 second shorter step", int'(sel), 1);
        drv = 1'b0;
        edges(15);
        drv = 1'b1; eq = 1'b0;
        edges(1);
        chk("R8 old capture used on adjust edge", int'(sel), 0);
        chk("R5 units at 0", int'(units), 1);
        drv = 1'b0;
        edges(16);
        chk("R3 recovery to longer", int'(sel), 1);
        drv = 1'b1; eq = 1'b0;
        edges(32);
        chk("R3 reach longest", int'(sel), 3);
        edges(16);
        chk("R3 saturate longest", int'(sel), 3);
        chk("R7 limit at 3", int'(lim), 1);
        eq = 1'b1;
        edges(1);
        drv = 1'b0; eq = 1'b0;
        edges(15);
        chk("R1 held capture ignores eq", int'(sel), 2);
        eq = 1'b1;
        edges(8);
        eq = 1'b0;
        edges(8);
        chk("R1 strobe low keeps capture", int'(sel), 1);
        drv = 1'b1; eq = 1'b1;
        edges(32);
        chk("R4 saturate shortest", int'(sel), 0);
        chk("R7 limit at 0", int'(lim), 1);

        for (int i = 0; i < 3000; i++) begin
            eq  = ($urandom_range(0, 3) != 0);
            drv = ($urandom_range(0, 1) != 0);
            edges(1);
        end

        rst_n = 1'b0;
        #1;
        chk("R6 async reset sel", int'(sel), 3);
        chk("R6 async reset units", int'(units), 7);
        edges(2);
        finish_run();
    end
endmodule